// File: doc/BRIEF.md
# Hub Downstream Port Enable Controller

This block keeps the enable state of the four downstream ports of a full-speed hub repeater. Three byte-wide registers hold one bit per port: connect status, port speed and port enable. A fourth register address holds a single interrupt flag. Firmware asks for a port to be enabled by writing its enable bit. The block applies that request at once when the upstream bus is idle. When a packet is being repeated, it holds the request until the packet ends. At the EOF2 point of each frame, hardware removes the enable of any port that is babbling.

The block also produces the per-port forwarding gates that the repeater uses. Downstream-bound traffic reaches a port only when the port is enabled and not suspended. Full-speed traffic is never sent to a low-speed port. Upstream-bound traffic from a port passes only when the port is enabled and is not being caught for babble in that cycle. While the hub is suspended, any change on a port's attach line sets a sticky interrupt flag, provided the hub interrupt is enabled. Firmware clears the flag by writing 1 to it.

The block sees line activity in abstract form only: a packet-in-flight level, an EOF2 strobe, per-port non-idle and upstream-link flags, and per-port end-of-packet flags.

Top module: `hub_port_gate`

## Requirements
- R1: Register bit n (n = 0..3) belongs to port n+1. The register is picked by `regSel`: 0 = connect status, 1 = speed, 2 = enable, 3 = interrupt flag (bit 0). Bits 7..4 of every register always read as zero, whatever was written to them.
- R2: An asynchronous active-low `rstN`, or a synchronous `busReset`, clears the connect, speed and enable registers, every pending enable request and the interrupt flag. All ports are disabled after either reset.
- R3: Writing 1 to a disabled port's enable bit while `pktActive` is low makes the bit read 1 in the next cycle.
- R4: Writing 1 to a disabled port's enable bit while `pktActive` is high keeps the bit at 0 until the first clock edge at which `pktActive` is low. The bit reads 1 after that edge. No enable bit rises after an edge at which `pktActive` was high.
- R5: Writing 0 to an enable bit clears it and cancels any pending request for that port. A bus reset also cancels pending requests.
- R6: When `eof2` is high, the enable bit (and any pending request) of each enabled port with `portNonIdle` high is cleared at that edge.
- R7: When `eof2` is high, the enable bit of each port with `portUpLink` high and `portEopSeen` low is cleared at that edge. A port whose `portEopSeen` is high keeps its enable.
- R8: When a babble clear and a firmware write of 1 hit the same enable bit in the same cycle, the bit ends at 0.
- R9: `dnFwd[n]` = enabled AND NOT `portSusp[n]` AND NOT (speed bit = 1 AND `upFullSpeed` = 1). The output is combinational on the current state.
- R10: `upFwd[n]` = enabled AND NOT (a babble condition of R6/R7 on port n in the current cycle).
- R11: A difference between `portAttached` and the connect register at an edge with `hubSuspend` and `hubIntEn` both high sets `hubIrq`. This holds even when the port is disabled. The flag stays set until firmware writes `regSel`=3 with bit 0 = 1. A set in the same cycle wins over that clear.
- R12: A write with `regSel`=1 loads bits 3..0 into the speed register (1 = low speed, 0 = full speed).
- R13: The connect register takes `portAttached` at every clock edge outside reset, so it shows a change one cycle later. Writes with `regSel`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| busReset | input | 1 | Synchronous bus reset, active high |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| portAttached | input | 4 | Per-port device attach line from the repeater |
| pktActive | input | 1 | A packet is being repeated |
| upFullSpeed | input | 1 | Current upstream traffic is full speed |
| eof2 | input | 1 | EOF2 frame-point strobe |
| portNonIdle | input | 4 | Per-port downstream line not idle |
| portUpLink | input | 4 | Per-port upstream connectivity established |
| portEopSeen | input | 4 | Per-port end of packet received |
| portSusp | input | 4 | Per-port suspended |
| hubSuspend | input | 1 | Hub is in suspend |
| hubIntEn | input | 1 | Hub interrupt enable |
| dnFwd | output | 4 | Forward upstream traffic to the port |
| upFwd | output | 4 | Pass the port's traffic upstream |
| hubIrq | output | 1 | Sticky hub interrupt flag |

## Verification
The bench aims at the deferred enable. It writes enables during a packet and checks the bit only after `pktActive` falls. A design that applied the write at once would show the port enabled mid-packet, and one that lost the request would never enable it. The bench writes 0 to a pending request and also bus-resets one. A design that kept a stale request would enable the port later with no write. It raises EOF2 babble together with a firmware write of 1, where reversed priority leaves the port enabled. It also exercises both babble causes, including the case where an EOP was seen and the port must stay enabled. The interrupt is checked for stickiness, for firing on a disabled port, for being held off when the hub is awake or interrupts are off, and for clearing on a write.

// File: rtl/hub_port_gate_pkg.sv
package hub_port_gate_pkg;
  localparam int NPORT = 4;
  localparam int REG_W = 8;
  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_CONN  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SPEED = 2'd1;
  localparam logic [SEL_W-1:0] SEL_EN    = 2'd2;
  localparam logic [SEL_W-1:0] SEL_IRQ   = 2'd3;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic [NPORT-1:0] babbleClr;
    logic [NPORT-1:0] raiseEn;
    logic [NPORT-1:0] setPend;
    logic [NPORT-1:0] dropBits;
    logic             spdWr;
    logic             irqSet;
    logic             irqClr;
  } ctlStrobe_t;
endpackage

// File: rtl/hub_port_gate_ctrl.sv
module hub_port_gate_ctrl
  import hub_port_gate_pkg::*;
(
  input  logic             wrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic [NPORT-1:0] wrLow,
  input  logic             pktActive,
  input  logic             eof2,
  input  logic [NPORT-1:0] portNonIdle,
  input  logic [NPORT-1:0] portUpLink,
  input  logic [NPORT-1:0] portEopSeen,
  input  logic [NPORT-1:0] portAttached,
  input  logic             hubSuspend,
  input  logic             hubIntEn,
  input  logic [NPORT-1:0] enState,
  input  logic [NPORT-1:0] pendState,
  input  logic [NPORT-1:0] connState,
  output ctlStrobe_t       ctl
);
  logic [NPORT-1:0] babbleHit;
  logic [NPORT-1:0] enWrOnes;
  logic [NPORT-1:0] enWrZeros;
  logic [NPORT-1:0] busyMask;
  logic             enWrite;

  assign enWrite  = wrEn && (regSel == SEL_EN);
  assign busyMask = {NPORT{pktActive}};

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      // Babble: traffic on an enabled port, or an open link with no EOP
      assign babbleHit[p] = eof2 &&
                            ((enState[p] && portNonIdle[p]) ||
                             (portUpLink[p] && !portEopSeen[p]));
      assign enWrOnes[p]  = enWrite && wrLow[p];
      assign enWrZeros[p] = enWrite && !wrLow[p];
    end
  endgenerate

  always_comb begin
    ctl = '0;
    ctl.babbleClr = babbleHit;
    ctl.dropBits  = enWrZeros;
    ctl.raiseEn   = ((enWrOnes & ~enState & ~busyMask) |
                     (pendState & ~busyMask & ~enWrZeros)) & ~babbleHit;
    ctl.setPend   = enWrOnes & ~enState & busyMask & ~babbleHit;
    ctl.spdWr     = wrEn && (regSel == SEL_SPEED);
    ctl.irqSet    = hubSuspend && hubIntEn && (portAttached != connState);
    ctl.irqClr    = wrEn && (regSel == SEL_IRQ) && wrLow[0];
  end
endmodule

// File: rtl/hub_port_gate_dp.sv
module hub_port_gate_dp
  import hub_port_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  ctlStrobe_t       ctl,
  input  logic [NPORT-1:0] wrLow,
  input  logic [NPORT-1:0] portAttached,
  input  logic [NPORT-1:0] portSusp,
  input  logic             upFullSpeed,
  input  logic [SEL_W-1:0] regSel,
  output logic [NPORT-1:0] enState,
  output logic [NPORT-1:0] pendState,
  output logic [NPORT-1:0] connState,
  output logic [NPORT-1:0] speedState,
  output logic             irqState,
  output logic [NPORT-1:0] dnFwd,
  output logic [NPORT-1:0] upFwd,
  output logic [REG_W-1:0] rdData
);
  localparam int PAD_W = REG_W - NPORT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enState    <= '0;
      pendState  <= '0;
      connState  <= '0;
      speedState <= '0;
      irqState   <= 1'b0;
    end else if (busReset) begin
      enState    <= '0;
      pendState  <= '0;
      connState  <= '0;
      speedState <= '0;
      irqState   <= 1'b0;
    end else begin
      enState   <= (enState | ctl.raiseEn) & ~ctl.dropBits & ~ctl.babbleClr;
      pendState <= (pendState | ctl.setPend) & ~ctl.raiseEn &
                   ~ctl.dropBits & ~ctl.babbleClr;
      connState <= portAttached;
      if (ctl.spdWr) speedState <= wrLow;
      irqState  <= ctl.irqSet || (irqState && !ctl.irqClr);
    end
  end

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_gate
      assign dnFwd[p] = enState[p] && !portSusp[p] &&
                        !(speedState[p] && upFullSpeed);
      assign upFwd[p] = enState[p] && !ctl.babbleClr[p];
    end
  endgenerate

  always_comb begin
    unique case (regSel)
      SEL_CONN:  rdData = {{PAD_W{1'b0}}, connState};
      SEL_SPEED: rdData = {{PAD_W{1'b0}}, speedState};
      SEL_EN:    rdData = {{PAD_W{1'b0}}, enState};
      default:   rdData = {{(REG_W-1){1'b0}}, irqState};
    endcase
  end
endmodule

// File: rtl/hub_port_gate.sv
module hub_port_gate
  import hub_port_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic [NPORT-1:0] portAttached,
  input  logic             pktActive,
  input  logic             upFullSpeed,
  input  logic             eof2,
  input  logic [NPORT-1:0] portNonIdle,
  input  logic [NPORT-1:0] portUpLink,
  input  logic [NPORT-1:0] portEopSeen,
  input  logic [NPORT-1:0] portSusp,
  input  logic             hubSuspend,
  input  logic             hubIntEn,
  output logic [NPORT-1:0] dnFwd,
  output logic [NPORT-1:0] upFwd,
  output logic             hubIrq
);
  ctlStrobe_t       ctl;
  logic [NPORT-1:0] wrLow;
  logic [NPORT-1:0] enState;
  logic [NPORT-1:0] pendState;
  logic [NPORT-1:0] connState;
  logic [NPORT-1:0] speedState;
  logic             unusedHiBits;

  assign wrLow        = wrData[NPORT-1:0];
  assign unusedHiBits = ^wrData[REG_W-1:NPORT];

  hub_port_gate_ctrl u_ctrl (
    .wrEn        (wrEn),
    .regSel      (regSel),
    .wrLow       (wrLow),
    .pktActive   (pktActive),
    .eof2        (eof2),
    .portNonIdle (portNonIdle),
    .portUpLink  (portUpLink),
    .portEopSeen (portEopSeen),
    .portAttached(portAttached),
    .hubSuspend  (hubSuspend),
    .hubIntEn    (hubIntEn),
    .enState     (enState),
    .pendState   (pendState),
    .connState   (connState),
    .ctl         (ctl)
  );

  hub_port_gate_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .busReset    (busReset),
    .ctl         (ctl),
    .wrLow       (wrLow),
    .portAttached(portAttached),
    .portSusp    (portSusp),
    .upFullSpeed (upFullSpeed),
    .regSel      (regSel),
    .enState     (enState),
    .pendState   (pendState),
    .connState   (connState),
    .speedState  (speedState),
    .irqState    (hubIrq),
    .dnFwd       (dnFwd),
    .upFwd       (upFwd),
    .rdData      (rdData)
  );
endmodule

// File: rtl/hub_port_gate_chk.sv
module hub_port_gate_chk
  import hub_port_gate_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busReset,
  input logic             wrEn,
  input logic [SEL_W-1:0] regSel,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic             pktActive,
  input logic             eof2,
  input logic [NPORT-1:0] portNonIdle,
  input logic [NPORT-1:0] portUpLink,
  input logic [NPORT-1:0] portEopSeen,
  input logic [NPORT-1:0] enState,
  input logic [NPORT-1:0] speedState,
  input logic [NPORT-1:0] connState,
  input logic [NPORT-1:0] dnFwd,
  input logic             hubIrq
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdData[REG_W-1:NPORT] == '0);

  p_bus_reset_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (enState == '0 && speedState == '0 && connState == '0 && !hubIrq));

  p_no_rise_in_packet_r4: assert property (@(posedge clk) disable iff (!rstN)
    pktActive |=> ((enState & ~$past(enState)) == '0));

  p_babble_traffic_r6: assert property (@(posedge clk) disable iff (!rstN)
    eof2 |=> ((enState & $past(enState & portNonIdle)) == '0));

  p_babble_no_eop_r7: assert property (@(posedge clk) disable iff (!rstN)
    eof2 |=> ((enState & $past(portUpLink & ~portEopSeen)) == '0));

  p_dn_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dnFwd & ~enState) == '0);

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (hubIrq && !(wrEn && regSel == SEL_IRQ && wrData[0]) && !busReset) |=> hubIrq);
endmodule

bind hub_port_gate hub_port_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .busReset(busReset), .wrEn(wrEn), .regSel(regSel),
  .wrData(wrData), .rdData(rdData), .pktActive(pktActive), .eof2(eof2),
  .portNonIdle(portNonIdle), .portUpLink(portUpLink), .portEopSeen(portEopSeen),
  .enState(enState), .speedState(speedState), .connState(connState),
  .dnFwd(dnFwd), .hubIrq(hubIrq)
);

// File: tb/hub_port_gate_bench.sv
`timescale 1ns/1ps
module hub_port_gate_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReset = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [3:0] portAttached = 4'd0;
  logic       pktActive = 1'b0;
  logic       upFullSpeed = 1'b0;
  logic       eof2 = 1'b0;
  logic [3:0] portNonIdle = 4'd0;
  logic [3:0] portUpLink = 4'd0;
  logic [3:0] portEopSeen = 4'd0;
  logic [3:0] portSusp = 4'd0;
  logic       hubSuspend = 1'b0;
  logic       hubIntEn = 1'b0;
  logic [3:0] dnFwd;
  logic [3:0] upFwd;
  logic       hubIrq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  // Reference state
  logic [3:0] mEn, mPend, mSpd, mConn;
  logic       mIrq;

  always #10 clk = ~clk;

  hub_port_gate u_hub_port_gate (.*);

  function automatic logic babbleOn(int p);
    return eof2 && ((mEn[p] && portNonIdle[p]) || (portUpLink[p] && !portEopSeen[p]));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN || (rstN && busReset)) begin
      mEn = '0; mPend = '0; mSpd = '0; mConn = '0; mIrq = 1'b0;
    end else begin
      logic [3:0] nEn, nPend;
      logic wrE, setI, clrI;
      nEn = mEn; nPend = mPend;
      wrE = wrEn && regSel == 2'd2;
      for (int p = 0; p < 4; p++) begin
        if (babbleOn(p)) begin nEn[p] = 0; nPend[p] = 0; end
        else if (wrE && !wrData[p]) begin nEn[p] = 0; nPend[p] = 0; end
        else if (mPend[p] && !pktActive) begin nEn[p] = 1; nPend[p] = 0; end
        else if (wrE && wrData[p] && !mEn[p]) begin
          if (pktActive) nPend[p] = 1; else nEn[p] = 1;
        end
      end
      setI = hubSuspend && hubIntEn && (portAttached != mConn);
      clrI = wrEn && regSel == 2'd3 && wrData[0];
      if (wrEn && regSel == 2'd1) mSpd = wrData[3:0];
      mIrq = setI || (mIrq && !clrI);
      mConn = portAttached;
      mEn = nEn; mPend = nPend;
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // Compare against the reference on every cycle
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [3:0] eDn, eUp;
      logic [7:0] eRd;
      for (int p = 0; p < 4; p++) begin
        eDn[p] = mEn[p] && !portSusp[p] && !(mSpd[p] && upFullSpeed);
        eUp[p] = mEn[p] && !babbleOn(p);
      end
      case (regSel)
        2'd0: eRd = {4'd0, mConn};
        2'd1: eRd = {4'd0, mSpd};
        2'd2: eRd = {4'd0, mEn};
        default: eRd = {7'd0, mIrq};
      endcase
      chk("R9 dnFwd", {4'd0, dnFwd}, {4'd0, eDn});
      chk("R10 upFwd", {4'd0, upFwd}, {4'd0, eUp});
      chk("R11 hubIrq", {7'd0, hubIrq}, {7'd0, mIrq});
      chk("R1 rdData", rdData, eRd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wrEn = 1; regSel = sel; wrData = d;
    tick();
    wrEn = 0;
  endtask

  task automatic rd(logic [1:0] sel, logic [7:0] exp, string tag);
    regSel = sel; #1;
    chk(tag, rdData, exp);
  endtask

  initial begin
    tick(2);
    rstN = 1;
    tick();
    rd(2'd0, 8'h00, "R2 conn after reset");
    rd(2'd1, 8'h00, "R2 speed after reset");
    rd(2'd2, 8'h00, "R2 enable after reset");
    rd(2'd3, 8'h00, "R2 irq after reset");

    // R13 connect follows attach; writes ignored
    portAttached = 4'b0101; tick();
    rd(2'd0, 8'h05, "R13 conn follows attach");
    wr(2'd0, 8'h0F);
    rd(2'd0, 8'h05, "R13 conn write ignored");

    // R12 speed write, R1 reserved bits
    wr(2'd1, 8'h0A);
    rd(2'd1, 8'h0A, "R12 speed written");
    wr(2'd1, 8'hF6);
    rd(2'd1, 8'h06, "R1 reserved bits zero");

    // R3 idle enable
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h01, "R3 idle enable immediate");

    // R4 deferred enable
    pktActive = 1;
    wr(2'd2, 8'h03);
    rd(2'd2, 8'h01, "R4 held during packet");
    tick(3);
    rd(2'd2, 8'h01, "R4 still held");
    pktActive = 0; tick();
    rd(2'd2, 8'h03, "R4 applied after packet");

    // R5 cancel by write 0 and by bus reset
    pktActive = 1;
    wr(2'd2, 8'h07);
    wr(2'd2, 8'h03);
    pktActive = 0; tick();
    rd(2'd2, 8'h03, "R5 write zero cancels pending");
    pktActive = 1;
    wr(2'd2, 8'h0B);
    busReset = 1; tick(); busReset = 0;
    rd(2'd2, 8'h00, "R2 bus reset clears enable");
    rd(2'd1, 8'h00, "R2 bus reset clears speed");
    pktActive = 0; tick();
    rd(2'd2, 8'h00, "R5 bus reset cancels pending");

    // R9 forwarding gates
    portAttached = 4'b1111;
    wr(2'd2, 8'h0F);
    wr(2'd1, 8'h08);
    portSusp = 4'b0010; upFullSpeed = 1; #1;
    chk("R9 dn gate full speed", {4'd0, dnFwd}, 8'h05);
    upFullSpeed = 0; #1;
    chk("R9 dn gate low speed traffic", {4'd0, dnFwd}, 8'h0D);
    portSusp = 4'b0000;

    // R6 / R10 babble on traffic
    portEopSeen = 4'b1111;
    eof2 = 1; portNonIdle = 4'b0001; #1;
    chk("R10 upFwd blocked by babble", {4'd0, upFwd}, 8'h0E);
    tick(); eof2 = 0; portNonIdle = 0;
    rd(2'd2, 8'h0E, "R6 non-idle babble clears");

    // R7 open link without EOP
    portUpLink = 4'b1000; portEopSeen = 4'b1000; eof2 = 1;
    tick(); eof2 = 0;
    rd(2'd2, 8'h0E, "R7 EOP seen keeps enable");
    portEopSeen = 4'b0000; portUpLink = 4'b0100; eof2 = 1;
    tick(); eof2 = 0; portUpLink = 0; portEopSeen = 4'b1111;
    rd(2'd2, 8'h0A, "R7 missing EOP clears");

    // R8 babble beats write
    eof2 = 1; portNonIdle = 4'b0010;
    wr(2'd2, 8'h0F);
    eof2 = 0; portNonIdle = 0;
    rd(2'd2, 8'h0D, "R8 babble wins over write");

    // R11 interrupt
    wr(2'd2, 8'h00);
    hubSuspend = 1; hubIntEn = 0; portAttached = 4'b1110; tick();
    rd(2'd3, 8'h00, "R11 no irq when disabled");
    hubSuspend = 0; hubIntEn = 1; portAttached = 4'b1100; tick();
    rd(2'd3, 8'h00, "R11 no irq when awake");
    hubSuspend = 1; portAttached = 4'b0100; tick();
    rd(2'd3, 8'h01, "R11 irq on disabled port");
    tick(3);
    rd(2'd3, 8'h01, "R11 irq sticky");
    wr(2'd3, 8'h01);
    rd(2'd3, 8'h00, "R11 write one clears");
    hubSuspend = 0;
    tick(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule